// File: doc/BRIEF.md
# SD Card Command Line Sequencer

This block is the card-side command engine of an SD/MMC host controller. A decoded command (6-bit index, 32-bit argument and a set of control flags) is handed over with a one-cycle start strobe. The engine then drives the single command line at the card clock. It can first send an 80-clock run of ones to initialise a freshly powered card, or hold the command back until a data transfer still in flight has finished. The command goes out as a 48-bit frame with its CRC7 computed on the fly.

After the frame the engine releases the line and listens. A response is optional, and when one is expected it is either 48 or 136 bits long. Its CRC7 can be checked or ignored per command. The engine reports completion, a missing response and a corrupted response as one-cycle pulses, and it presents the captured response bits. A separate boot path holds the command line low until a boot-stop command arrives. While that path is active it can watch the acknowledge line for a 0-1-0 start pattern.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: A command frame is shifted out MSB first, one bit per clock, starting in the cycle after the start strobe is taken. The frame is: bit 47 = 0, bit 46 = 1, bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC7 of bits 47:8 with generator x^7+x^3+1 (initial value 0), and bit 0 = 1. The line is driven (`cmd_oe` = 1) throughout.
- R2: With `init_seq` set, 80 cycles of driven ones precede the frame, and the frame follows directly after them.
- R3: With `wait_prev` set and `data_busy` high, the line stays released and the engine stays busy until `data_busy` falls. The first frame bit appears in the cycle after the clock edge that samples `data_busy` low. With `wait_prev` clear, the frame starts at once regardless of `data_busy`.
- R4: With `resp_expect` clear, `cmd_done` is high for exactly one cycle, in the cycle after the end bit. In that cycle the line is released and `busy` is low.
- R5: With `resp_expect` set, the line is released after the end bit and a response is received. It is 48 bits long when `resp_long` = 0 and 136 bits when it is 1, and the first bit is the first 0 sampled. After the response end bit, `cmd_done` pulses and `resp_bits` holds the response, first bit most significant and right-aligned; a short response has its upper 88 bits zero.
- R6: The engine samples the released line at up to 64 clock edges looking for the start bit. If the line is low at the 64th of those edges, the response is accepted. If all 64 samples are high, `resp_timeout` pulses for one cycle with no `cmd_done`, and the engine goes idle.
- R7: With `resp_crc_chk` set, `resp_crc_err` pulses together with `cmd_done` when the received bits 7:1 differ from the CRC7 of the covered bits. For a short response the covered bits are bits 47:8. For a long response they are bits 127:8, so the first 8 header bits are excluded.
- R8: With `resp_crc_chk` clear, a CRC mismatch never raises `resp_crc_err`.
- R9: A start with `boot_enable` set drives the line low from the next cycle and holds it low. This holds even when `init_seq` is also set, so no preamble is sent in boot. The hold ends only on a start with `boot_disable` set; that start causes a one-cycle `cmd_done` with the line released.
- R10: In boot with `boot_ack_expect` set, the engine looks for `boot_ack_in` sampled 0, 1, 0 on consecutive edges within the first 64 edges of the hold. If the pattern is absent, `boot_ack_err` pulses once after the 64th sample. If `boot_ack_expect` is clear, no error is raised.
- R11: After reset the line is released, `busy` and every pulse output are low and `resp_bits` is zero. A start strobe while busy is ignored, except a boot-stop start during a boot hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle strobe that hands over a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_expect | input | 1 | A response follows the command |
| resp_long | input | 1 | Response is 136 bits instead of 48 |
| resp_crc_chk | input | 1 | Check the response CRC7 |
| init_seq | input | 1 | Send 80 ones before the frame |
| wait_prev | input | 1 | Hold the command while data_busy is high |
| boot_enable | input | 1 | Start a boot hold (line low) |
| boot_disable | input | 1 | End a boot hold |
| boot_ack_expect | input | 1 | Watch for the 0-1-0 boot acknowledge |
| data_busy | input | 1 | A previous data transfer is still running |
| cmd_in | input | 1 | Sampled command line level |
| boot_ack_in | input | 1 | Sampled boot acknowledge line level |
| cmd_out | output | 1 | Level driven onto the command line |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Engine is not idle |
| cmd_done | output | 1 | Command or boot hold finished (pulse) |
| resp_timeout | output | 1 | No response start bit seen (pulse) |
| resp_crc_err | output | 1 | Response CRC7 mismatch (pulse) |
| boot_ack_err | output | 1 | Boot acknowledge pattern missing (pulse) |
| resp_bits | output | 136 | Last received response |

## Verification
The hardest conditions to reach are the two window edges: a response start bit on exactly the 64th released-line sample, and a boot acknowledge that is absent until the 64th sample of the hold. Neither can be provoked through the command interface alone. The bench therefore plays the card itself and drives `cmd_in` and `boot_ack_in` sample by sample from the falling clock edge. It sweeps the number of idle-high samples before the response start up to the last accepted position and one past it. It also counts the hold cycles before checking for the acknowledge error pulse.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int BODY_BITS  = 40;
  localparam int CRC_BITS   = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAITD,
    S_PRE,
    S_SEND,
    S_TURN,
    S_RECV,
    S_BOOT
  } seq_state_t;

  typedef struct packed {
    logic resp_on;
    logic resp_long;
    logic crc_on;
    logic init_on;
    logic ack_on;
  } cmd_flags_t;

  // One serial step of the CRC7 divider, generator x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // Number of response bits for the selected length.
  function automatic logic [7:0] resp_len(input logic is_long);
    return is_long ? 8'(LONG_BITS) : 8'(FRAME_BITS);
  endfunction

  // Whether received bit number k takes part in the response CRC.
  function automatic logic crc_covers(input logic is_long, input logic [7:0] k);
    if (is_long) return (k >= 8'd8) && (k < 8'd128);
    return k < 8'(BODY_BITS);
  endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic        shift,
  output logic        bit_o,
  output logic        last_o
);

  logic [BODY_BITS-1:0] body;
  logic [CRC_BITS-1:0]  crc;
  logic [5:0]           pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      body <= '0;
      crc  <= '0;
      pos  <= '0;
    end else if (load) begin
      body <= {1'b0, 1'b1, idx, arg};
      crc  <= '0;
      pos  <= '0;
    end else if (shift) begin
      pos <= pos + 6'd1;
      if (pos < 6'(BODY_BITS)) begin
        body <= {body[BODY_BITS-2:0], 1'b0};
        crc  <= crc7_step(crc, body[BODY_BITS-1]);
      end else begin
        crc  <= {crc[CRC_BITS-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    if (pos < 6'(BODY_BITS))             bit_o = body[BODY_BITS-1];
    else if (pos < 6'(FRAME_BITS - 1))   bit_o = crc[CRC_BITS-1];
    else                                 bit_o = 1'b1;
  end

  assign last_o = shift && (pos == 6'(FRAME_BITS - 1));

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 sample,
  input  logic                 long_sel,
  input  logic                 bit_i,
  output logic                 last_o,
  output logic                 crc_ok_o,
  output logic [LONG_BITS-1:0] resp_o
);

  logic [LONG_BITS-2:0] sr;
  logic [7:0]           cnt;
  logic [6:0]           acc;

  assign last_o   = sample && (cnt == resp_len(long_sel) - 8'd1);
  assign crc_ok_o = (acc == sr[6:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      acc    <= '0;
      resp_o <= '0;
    end else if (clear) begin
      sr  <= '0;
      cnt <= '0;
      acc <= '0;
    end else if (sample) begin
      sr  <= {sr[LONG_BITS-3:0], bit_i};
      cnt <= cnt + 8'd1;
      if (crc_covers(long_sel, cnt)) acc <= crc7_step(acc, bit_i);
      if (last_o) begin
        if (long_sel) resp_o <= {sr, bit_i};
        else          resp_o <= {{(LONG_BITS-FRAME_BITS){1'b0}}, sr[FRAME_BITS-2:0], bit_i};
      end
    end
  end

endmodule

// File: rtl/sd_boot_ack.sv
module sd_boot_ack #(
  parameter int WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic ack_i,
  output logic miss_o
);

  localparam int AW = $clog2(WIN + 1);

  logic [1:0]    hist;
  logic [AW-1:0] cnt;
  logic          seen;
  logic          closed;
  logic          match;

  // hist[1] is the older sample; a hit is older 0, middle 1, current 0
  assign match = (hist == 2'b01) && !ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= 2'b11;
      cnt    <= '0;
      seen   <= 1'b0;
      closed <= 1'b0;
      miss_o <= 1'b0;
    end else begin
      miss_o <= 1'b0;
      if (clear) begin
        hist   <= 2'b11;
        cnt    <= '0;
        seen   <= 1'b0;
        closed <= 1'b0;
      end else if (en && !closed) begin
        hist <= {hist[0], ack_i};
        seen <= seen | match;
        if (cnt == AW'(WIN - 1)) begin
          closed <= 1'b1;
          miss_o <= !(seen | match);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer
  import sd_cmd_pkg::*;
#(
  parameter int INIT_CYCLES  = 80,
  parameter int RESP_TIMEOUT = 64,
  parameter int ACK_WINDOW   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_start,
  input  logic [5:0]           cmd_index,
  input  logic [31:0]          cmd_arg,
  input  logic                 resp_expect,
  input  logic                 resp_long,
  input  logic                 resp_crc_chk,
  input  logic                 init_seq,
  input  logic                 wait_prev,
  input  logic                 boot_enable,
  input  logic                 boot_disable,
  input  logic                 boot_ack_expect,
  input  logic                 data_busy,
  input  logic                 cmd_in,
  input  logic                 boot_ack_in,
  output logic                 cmd_out,
  output logic                 cmd_oe,
  output logic                 busy,
  output logic                 cmd_done,
  output logic                 resp_timeout,
  output logic                 resp_crc_err,
  output logic                 boot_ack_err,
  output logic [LONG_BITS-1:0] resp_bits
);

  localparam int CNT_TOP = (INIT_CYCLES > RESP_TIMEOUT) ? INIT_CYCLES : RESP_TIMEOUT;
  localparam int CW      = $clog2(CNT_TOP + 1);

  seq_state_t st;
  cmd_flags_t flg;
  logic [CW-1:0] cnt;

  // named events for the checker
  logic in_pre, in_send, in_wait, in_boot, in_listen, crc_flag;
  logic take_cmd, take_boot, tx_load, tx_bit, tx_last;
  logic rx_clear, rx_sample, rx_last, rx_crc_ok;
  logic ack_clear, ack_en;

  assign in_pre    = (st == S_PRE);
  assign in_send   = (st == S_SEND);
  assign in_wait   = (st == S_WAITD);
  assign in_boot   = (st == S_BOOT);
  assign in_listen = (st == S_TURN) || (st == S_RECV);
  assign crc_flag  = flg.crc_on;

  assign take_cmd  = (st == S_IDLE) && cmd_start;
  assign take_boot = take_cmd && boot_enable;
  assign tx_load   = take_cmd && !boot_enable;
  assign rx_clear  = in_send && tx_last;
  assign rx_sample = ((st == S_TURN) && !cmd_in) || (st == S_RECV);
  assign ack_clear = take_boot;
  assign ack_en    = in_boot && flg.ack_on;

  sd_cmd_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tx_load),
    .idx    (cmd_index),
    .arg    (cmd_arg),
    .shift  (in_send),
    .bit_o  (tx_bit),
    .last_o (tx_last)
  );

  sd_cmd_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rx_clear),
    .sample   (rx_sample),
    .long_sel (flg.resp_long),
    .bit_i    (cmd_in),
    .last_o   (rx_last),
    .crc_ok_o (rx_crc_ok),
    .resp_o   (resp_bits)
  );

  sd_boot_ack #(.WIN(ACK_WINDOW)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ack_clear),
    .en     (ack_en),
    .ack_i  (boot_ack_in),
    .miss_o (boot_ack_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      flg          <= '0;
      cnt          <= '0;
      cmd_done     <= 1'b0;
      resp_timeout <= 1'b0;
      resp_crc_err <= 1'b0;
    end else begin
      cmd_done     <= 1'b0;
      resp_timeout <= 1'b0;
      resp_crc_err <= 1'b0;
      unique case (st)
        S_IDLE: if (cmd_start) begin
          flg.resp_on   <= resp_expect;
          flg.resp_long <= resp_long;
          flg.crc_on    <= resp_crc_chk;
          flg.init_on   <= init_seq && !boot_enable;
          flg.ack_on    <= boot_ack_expect;
          cnt           <= '0;
          if (boot_enable)                st <= S_BOOT;
          else if (wait_prev && data_busy) st <= S_WAITD;
          else if (init_seq)              st <= S_PRE;
          else                            st <= S_SEND;
        end
        S_WAITD: if (!data_busy) st <= flg.init_on ? S_PRE : S_SEND;
        S_PRE: begin
          if (cnt == CW'(INIT_CYCLES - 1)) st <= S_SEND;
          else                             cnt <= cnt + 1'b1;
        end
        S_SEND: if (tx_last) begin
          cnt <= '0;
          if (flg.resp_on) begin
            st <= S_TURN;
          end else begin
            st       <= S_IDLE;
            cmd_done <= 1'b1;
          end
        end
        S_TURN: begin
          if (!cmd_in) begin
            st <= S_RECV;
          end else if (cnt == CW'(RESP_TIMEOUT - 1)) begin
            st           <= S_IDLE;
            resp_timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RECV: if (rx_last) begin
          st           <= S_IDLE;
          cmd_done     <= 1'b1;
          resp_crc_err <= flg.crc_on && !rx_crc_ok;
        end
        S_BOOT: if (cmd_start && boot_disable) begin
          st       <= S_IDLE;
          cmd_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign cmd_oe = in_pre || in_send || in_boot;

  always_comb begin
    if (in_send)      cmd_out = tx_bit;
    else if (in_boot) cmd_out = 1'b0;
    else              cmd_out = 1'b1;
  end

endmodule

// File: rtl/sd_cmd_sequencer_chk.sv
module sd_cmd_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_oe,
  input logic cmd_out,
  input logic busy,
  input logic cmd_done,
  input logic resp_timeout,
  input logic resp_crc_err,
  input logic boot_ack_err,
  input logic in_pre,
  input logic in_send,
  input logic in_wait,
  input logic in_boot,
  input logic in_listen,
  input logic crc_flag
);

  a_r1_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_send) |-> cmd_oe && !cmd_out);

  a_r2_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_pre |-> cmd_oe && cmd_out);

  a_r3_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !cmd_oe && busy);

  a_r4_listen_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_listen |-> !cmd_oe);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r6_timeout_alone: assert property (@(posedge clk) disable iff (!rst_n)
    resp_timeout |-> !cmd_done && !busy);

  a_r8_crc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    resp_crc_err |-> cmd_done && crc_flag);

  a_r9_boot_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_boot |-> cmd_oe && !cmd_out);

  a_r10_miss_once: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ack_err |=> !boot_ack_err);

endmodule

bind sd_cmd_sequencer sd_cmd_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_oe       (cmd_oe),
  .cmd_out      (cmd_out),
  .busy         (busy),
  .cmd_done     (cmd_done),
  .resp_timeout (resp_timeout),
  .resp_crc_err (resp_crc_err),
  .boot_ack_err (boot_ack_err),
  .in_pre       (in_pre),
  .in_send      (in_send),
  .in_wait      (in_wait),
  .in_boot      (in_boot),
  .in_listen    (in_listen),
  .crc_flag     (crc_flag)
);

// File: tb/sd_cmd_sequencer_bench.sv
module sd_cmd_sequencer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic resp_expect = 1'b0, resp_long = 1'b0, resp_crc_chk = 1'b0, init_seq = 1'b0;
  logic wait_prev = 1'b0, boot_enable = 1'b0, boot_disable = 1'b0, boot_ack_expect = 1'b0;
  logic data_busy = 1'b0, cmd_in = 1'b1, boot_ack_in = 1'b1;
  logic cmd_out, cmd_oe, busy, cmd_done, resp_timeout, resp_crc_err, boot_ack_err;
  logic [135:0] resp_bits;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sd_cmd_sequencer u_sd_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .resp_expect(resp_expect), .resp_long(resp_long),
    .resp_crc_chk(resp_crc_chk), .init_seq(init_seq), .wait_prev(wait_prev),
    .boot_enable(boot_enable), .boot_disable(boot_disable),
    .boot_ack_expect(boot_ack_expect), .data_busy(data_busy), .cmd_in(cmd_in),
    .boot_ack_in(boot_ack_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
    .cmd_done(cmd_done), .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err),
    .boot_ack_err(boot_ack_err), .resp_bits(resp_bits)
  );

  task automatic check(input bit ok, input string req, input logic [135:0] act,
                       input logic [135:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // CRC7 by long division of msg * x^7 by 0x89; msg occupies its low n bits.
  function automatic logic [6:0] ref_crc(input logic [119:0] msg, input int n);
    logic [126:0] r;
    r = {msg, 7'b0};
    for (int i = n + 6; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [47:0] mk_short(input logic tbit, input logic [5:0] idx,
                                           input logic [31:0] arg);
    logic [39:0] body;
    body = {1'b0, tbit, idx, arg};
    return {body, ref_crc({80'b0, body}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] pay);
    return {2'b00, 6'h3f, pay, ref_crc(pay, 120), 1'b1};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                       input logic re, input logic rl, input logic cc, input logic ini,
                       input logic wp, input logic be, input logic bd, input logic ba);
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; resp_expect = re; resp_long = rl;
    resp_crc_chk = cc; init_seq = ini; wait_prev = wp; boot_enable = be;
    boot_disable = bd; boot_ack_expect = ba; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; boot_enable = 1'b0; boot_disable = 1'b0;
  endtask

  task automatic expect_stream(input logic [47:0] fr, input int pre, input string req);
    int errs;
    logic [47:0] got;
    logic e;
    errs = 0;
    got = '0;
    for (int i = 0; i < pre + 48; i++) begin
      if (i > 0) @(negedge clk);
      e = (i < pre) ? 1'b1 : fr[47 - (i - pre)];
      if (!(cmd_oe === 1'b1 && cmd_out === e)) errs++;
      if (i >= pre) got = {got[46:0], cmd_out};
    end
    cmd_in = 1'b1;
    check(errs == 0, req, {88'b0, got}, {88'b0, fr});
  endtask

  task automatic respond(input int hi, input logic [135:0] bits, input int n);
    for (int k = 0; k < hi; k++) begin @(negedge clk); cmd_in = 1'b1; end
    for (int b = 0; b < n; b++) begin @(negedge clk); cmd_in = bits[n - 1 - b]; end
    @(negedge clk);
    cmd_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] fr, rs;
    logic [135:0] lr;
    logic [119:0] pay;
    logic [31:0] a;
    int first, cnt_err, errs;
    int delays [6] = '{0, 1, 5, 17, 40, 63};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(cmd_oe == 0 && busy == 0 && cmd_done == 0 && resp_timeout == 0 &&
          resp_crc_err == 0 && boot_ack_err == 0, "R11 reset outputs",
          {130'b0, cmd_oe, busy, cmd_done, resp_timeout, resp_crc_err, boot_ack_err}, '0);
    check(resp_bits == '0, "R11 reset response", resp_bits, '0);

    // R1 / R4: sweep every command index without response
    for (int i = 0; i < 64; i++) begin
      a = 32'h9E3779B9 * 32'(i + 1);
      fr = mk_short(1'b1, 6'(i), a);
      issue(6'(i), a, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_stream(fr, 0, "R1 frame bits");
      @(negedge clk);
      check(cmd_done == 1 && cmd_oe == 0 && busy == 0, "R4 done after end bit",
            {133'b0, cmd_done, cmd_oe, busy}, 136'b100);
      @(negedge clk);
      check(cmd_done == 0, "R4 done single cycle", {135'b0, cmd_done}, '0);
    end

    // R2: preamble of 80 ones before the frame
    fr = mk_short(1'b1, 6'd0, 32'h0);
    issue(6'd0, 32'h0, 0, 0, 0, 1, 0, 0, 0, 0);
    expect_stream(fr, 80, "R2 preamble then frame");
    @(negedge clk);
    check(cmd_done == 1, "R2 done after preamble command", {135'b0, cmd_done}, 136'b1);

    // R3: hold while data busy
    data_busy = 1'b1;
    fr = mk_short(1'b1, 6'd13, 32'h0000_1234);
    issue(6'd13, 32'h0000_1234, 0, 0, 0, 0, 1, 0, 0, 0);
    errs = 0;
    for (int k = 0; k < 10; k++) begin
      if (cmd_oe !== 1'b0 || busy !== 1'b1) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R3 released while data busy", 136'(errs), '0);
    data_busy = 1'b0;
    @(negedge clk);
    expect_stream(fr, 0, "R3 frame after data idle");
    @(negedge clk);
    check(cmd_done == 1, "R3 done after held command", {135'b0, cmd_done}, 136'b1);

    // R3: wait flag clear, busy data ignored
    data_busy = 1'b1;
    fr = mk_short(1'b1, 6'd12, 32'hCAFE_0001);
    issue(6'd12, 32'hCAFE_0001, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R3 immediate without wait");
    data_busy = 1'b0;
    @(negedge clk);

    // R5 / R6: short responses at several turnaround lengths, up to the last accepted
    foreach (delays[j]) begin
      a = 32'h1000_0000 + 32'(delays[j] * 77);
      fr = mk_short(1'b1, 6'd17, a);
      rs = mk_short(1'b0, 6'd17, a ^ 32'h00FF_00FF);
      issue(6'd17, a, 1, 0, 1, 0, 0, 0, 0, 0);
      expect_stream(fr, 0, "R1 frame before response");
      respond(delays[j], {88'b0, rs}, 48);
      check(cmd_done == 1 && resp_crc_err == 0 && resp_timeout == 0,
            delays[j] == 63 ? "R6 start bit on last sample" : "R5 short done",
            {133'b0, cmd_done, resp_crc_err, resp_timeout}, 136'b100);
      check(resp_bits == {88'b0, rs}, "R5 short captured", resp_bits, {88'b0, rs});
    end

    // R5 / R7: long response with good CRC
    pay = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 24'h5A5A5A};
    lr = mk_long(pay);
    fr = mk_short(1'b1, 6'd2, 32'h0);
    issue(6'd2, 32'h0, 1, 1, 1, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before long");
    respond(3, lr, 136);
    check(cmd_done == 1 && resp_crc_err == 0, "R7 long good CRC",
          {134'b0, cmd_done, resp_crc_err}, 136'b10);
    check(resp_bits == lr, "R5 long captured", resp_bits, lr);

    // R7: long response with header changed only (outside coverage), still good
    issue(6'd2, 32'h0, 1, 1, 1, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before long header");
    respond(2, {lr[135:130], 2'b10, lr[127:0]}, 136);
    check(cmd_done == 1 && resp_crc_err == 0, "R7 long header not covered",
          {134'b0, cmd_done, resp_crc_err}, 136'b10);

    // R7: corrupted CRC, short and long
    rs = mk_short(1'b0, 6'd3, 32'h55AA_55AA);
    fr = mk_short(1'b1, 6'd3, 32'h55AA_55AA);
    issue(6'd3, 32'h55AA_55AA, 1, 0, 1, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before bad short");
    respond(4, {88'b0, rs ^ 48'h0000_0000_0004}, 48);
    check(cmd_done == 1 && resp_crc_err == 1, "R7 short CRC error",
          {134'b0, cmd_done, resp_crc_err}, 136'b11);
    @(negedge clk);
    check(resp_crc_err == 0, "R7 error single cycle", {135'b0, resp_crc_err}, '0);

    fr = mk_short(1'b1, 6'd2, 32'h0);
    issue(6'd2, 32'h0, 1, 1, 1, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before bad long");
    respond(1, lr ^ (136'b1 << 60), 136);
    check(cmd_done == 1 && resp_crc_err == 1, "R7 long CRC error",
          {134'b0, cmd_done, resp_crc_err}, 136'b11);

    // R8: same corruption with checking disabled
    issue(6'd2, 32'h0, 1, 1, 0, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before unchecked long");
    respond(1, lr ^ (136'b1 << 60), 136);
    check(cmd_done == 1 && resp_crc_err == 0, "R8 long unchecked",
          {134'b0, cmd_done, resp_crc_err}, 136'b10);
    fr = mk_short(1'b1, 6'd3, 32'h55AA_55AA);
    issue(6'd3, 32'h55AA_55AA, 1, 0, 0, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before unchecked short");
    respond(4, {88'b0, rs ^ 48'h0000_0000_0004}, 48);
    check(cmd_done == 1 && resp_crc_err == 0, "R8 short unchecked",
          {134'b0, cmd_done, resp_crc_err}, 136'b10);

    // R6: timeout after 64 high samples
    fr = mk_short(1'b1, 6'd9, 32'h0BAD_F00D);
    issue(6'd9, 32'h0BAD_F00D, 1, 0, 1, 0, 0, 0, 0, 0);
    expect_stream(fr, 0, "R1 frame before timeout");
    errs = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      cmd_in = 1'b1;
      if (resp_timeout !== 1'b0 || cmd_oe !== 1'b0) errs++;
    end
    check(errs == 0, "R6 no early timeout, line released", 136'(errs), '0);
    @(negedge clk);
    check(resp_timeout == 1 && cmd_done == 0 && busy == 0, "R6 timeout pulse",
          {133'b0, resp_timeout, cmd_done, busy}, 136'b100);
    @(negedge clk);
    check(resp_timeout == 0, "R6 timeout single cycle", {135'b0, resp_timeout}, '0);

    // R9 / R10 / R11: boot hold with missing acknowledge, stray start ignored
    issue(6'd0, 32'h0, 0, 0, 0, 1, 0, 1, 0, 1);
    check(cmd_oe == 1 && cmd_out == 0, "R9 boot drives low, no preamble",
          {134'b0, cmd_oe, cmd_out}, 136'b10);
    first = -1; cnt_err = 0; errs = 0;
    for (int k = 0; k < 100; k++) begin
      if (boot_ack_err) begin cnt_err++; if (first < 0) first = k; end
      if (cmd_oe !== 1'b1 || cmd_out !== 1'b0 || busy !== 1'b1) errs++;
      boot_ack_in = 1'b1;
      cmd_start = (k == 30);
      @(negedge clk);
    end
    cmd_start = 1'b0;
    check(errs == 0, "R11 stray start ignored, R9 line held low", 136'(errs), '0);
    check(first == 64, "R10 miss after 64th sample", 136'(first), 136'd64);
    check(cnt_err == 1, "R10 miss pulses once", 136'(cnt_err), 136'd1);
    issue(6'd0, 32'h0, 0, 0, 0, 0, 0, 0, 1, 0);
    check(cmd_done == 1 && cmd_oe == 0 && busy == 0, "R9 boot stop",
          {133'b0, cmd_done, cmd_oe, busy}, 136'b100);

    // R10: acknowledge pattern present
    issue(6'd0, 32'h0, 0, 0, 0, 0, 0, 1, 0, 1);
    cnt_err = 0;
    for (int k = 0; k < 100; k++) begin
      if (boot_ack_err) cnt_err++;
      boot_ack_in = (k == 5 || k == 7) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    check(cnt_err == 0, "R10 pattern seen, no error", 136'(cnt_err), '0);
    issue(6'd0, 32'h0, 0, 0, 0, 0, 0, 0, 1, 0);
    check(cmd_done == 1, "R9 boot stop after ack", {135'b0, cmd_done}, 136'b1);

    // R10: acknowledge not expected
    issue(6'd0, 32'h0, 0, 0, 0, 0, 0, 1, 0, 0);
    cnt_err = 0;
    for (int k = 0; k < 100; k++) begin
      if (boot_ack_err) cnt_err++;
      boot_ack_in = 1'b1;
      @(negedge clk);
    end
    check(cnt_err == 0, "R10 no check when not expected", 136'(cnt_err), '0);
    issue(6'd0, 32'h0, 0, 0, 0, 0, 0, 0, 1, 0);
    check(cmd_done == 1 && cmd_oe == 0, "R9 boot stop without ack",
          {134'b0, cmd_done, cmd_oe}, 136'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule